// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps micro-ops that are in flight in program order inside a circular store of entries. The entry number of each micro-op is also its physical register tag. A rename stage asks for up to four entries per cycle. If enough entries are free, the block grants the request and hands back the tags, which are consecutive modulo the depth. Execution units return results by tag, together with an exception flag and a branch-mispredict flag. Consumers can look up a tag at any time to get its value and a ready bit.

Each cycle, the block looks at the oldest four entries. It commits the longest run of them that have executed, starting from the oldest, and writes their results to architectural register write ports.

- A faulting entry is not committed. It ends the run and raises an exception flush carrying its index.
- A mispredicted entry is committed and then ends the run with a plain flush.
- Either flush throws away every younger entry and leaves the buffer empty. Allocation then restarts at tag 0.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: no retire slot is valid, flush is low, and a request of four entries is granted with tags 0,1,2,3.
- R2: A granted request of N entries returns in slots 0..N-1 the tags T, T+1, ... modulo DEPTH (40), where T is the tag after the last granted entry. Slot k's tag occupies bits [6k+5:6k] of alloc_tag.
- R3: A request is refused (alloc_ok low) when the current number of free entries is smaller than the request. A refused request allocates nothing, and later grants continue from the same tag.
- R4: A lookup reports lk_ready=0 for an entry that has not been written back. Once it is written back, the lookup reports its value with lk_ready=1. When a write-back to the looked-up tag happens in the same cycle, the lookup returns the new value at once.
- R5: In each cycle, retire slot k (bit k of ret_valid) carries the k-th oldest entry. Only a contiguous run from slot 0 of executed entries retires, up to four. An entry that has not executed blocks every younger one.
- R6: A retired entry with a destination drives ret_we[k]=1, its destination register number on ret_addr bits [3k+2:3k] and its result on ret_data bits [32k+31:32k]. An entry without a destination retires with ret_we[k]=0.
- R7: A retiring mispredicted entry is committed and raises flush with flush_exc=0 and flush_tag equal to its index. Younger entries do not retire. The next cycle the buffer is empty and allocation restarts at tag 0.
- R8: An executed entry flagged with an exception is not committed; older entries in the same cycle still are. It raises flush with flush_exc=1 and flush_tag equal to its index, and the buffer is empty in the next cycle.
- R9: During a flush cycle no allocation is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | 3 | Number of entries requested this cycle (0..4) |
| alloc_has_dst | input | 4 | Per slot: micro-op writes a destination |
| alloc_dst | input | 12 | Per slot destination architectural register, 3 bits each |
| alloc_ok | output | 1 | Request granted this cycle |
| alloc_tag | output | 24 | Per slot tag, 6 bits each |
| wb_valid | input | 1 | Write-back strobe |
| wb_tag | input | 6 | Entry written back |
| wb_data | input | 32 | Result value |
| wb_exc | input | 1 | Micro-op faulted |
| wb_misp | input | 1 | Branch was mispredicted |
| lk_tag | input | 6 | Tag looked up |
| lk_data | output | 32 | Value of the looked-up entry |
| lk_ready | output | 1 | Value has been produced |
| ret_valid | output | 4 | Per slot: entry retires this cycle |
| ret_we | output | 4 | Per slot: architectural register write |
| ret_addr | output | 12 | Per slot destination register, 3 bits each |
| ret_data | output | 128 | Per slot result, 32 bits each |
| flush | output | 1 | Discard all younger work this cycle |
| flush_exc | output | 1 | Flush is caused by an exception |
| flush_tag | output | 6 | Index of the entry causing the flush |

## Verification
A wrong head pointer or count would show up as wrong data or register numbers on the retire ports, or as a retire-slot pattern that breaks the run-from-oldest rule. This appears in the first cycle in which the affected entries become eligible. A wrong tail pointer or free count shows in the tags or in the grant decision of the very next request. That includes the request that crosses the top of the buffer, and the one made when it is full. A flush that fails to empty the buffer is seen the following cycle, as a non-zero first tag or as retirements of entries that should be gone.

// File: rtl/rob_pkg.sv
package rob_pkg;
    // one-step circular wrap of an index that may exceed the depth by less than one lap
    function automatic int rob_wrap(input int v, input int depth);
        return (v >= depth) ? v - depth : v;
    endfunction
endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
    parameter int DEPTH = 40,
    parameter int WIDTH = 4,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int REQ_W = $clog2(WIDTH + 1)
) (
    input  logic [TAG_W-1:0]       tail,
    input  logic [CNT_W-1:0]       count,
    input  logic [REQ_W-1:0]       req_cnt,
    input  logic                   flush,
    output logic                   grant,
    output logic                   fire,
    output logic [WIDTH*TAG_W-1:0] tags
);
    assign grant = !flush && ((DEPTH - int'(count)) >= int'(req_cnt));
    assign fire  = grant && (req_cnt != '0);

    for (genvar k = 0; k < WIDTH; k++) begin : g_tag
        assign tags[k*TAG_W +: TAG_W] = TAG_W'(rob_pkg::rob_wrap(int'(tail) + k, DEPTH));
    end
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
    parameter int DEPTH  = 40,
    parameter int WIDTH  = 4,
    parameter int DATA_W = 32,
    parameter int AREG_W = 3,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REQ_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0]        w_valid,
    input  logic [WIDTH-1:0]        w_exec,
    input  logic [WIDTH-1:0]        w_exc,
    input  logic [WIDTH-1:0]        w_misp,
    input  logic [WIDTH-1:0]        w_has_dst,
    input  logic [WIDTH*AREG_W-1:0] w_dst,
    input  logic [WIDTH*DATA_W-1:0] w_data,
    input  logic [WIDTH*TAG_W-1:0]  w_idx,
    output logic [WIDTH-1:0]        ret_valid,
    output logic [WIDTH-1:0]        ret_we,
    output logic [WIDTH*AREG_W-1:0] ret_addr,
    output logic [WIDTH*DATA_W-1:0] ret_data,
    output logic [REQ_W-1:0]        ret_cnt,
    output logic                    flush,
    output logic                    flush_exc,
    output logic [TAG_W-1:0]        flush_tag
);
    assign ret_addr = w_dst;
    assign ret_data = w_data;

    always_comb begin
        logic stop;
        stop      = 1'b0;
        ret_valid = '0;
        ret_we    = '0;
        ret_cnt   = '0;
        flush     = 1'b0;
        flush_exc = 1'b0;
        flush_tag = '0;
        for (int k = 0; k < WIDTH; k++) begin
            if (!stop) begin
                if (w_valid[k] && w_exec[k]) begin
                    if (w_exc[k]) begin
                        flush     = 1'b1;
                        flush_exc = 1'b1;
                        flush_tag = w_idx[k*TAG_W +: TAG_W];
                        stop      = 1'b1;
                    end else begin
                        ret_valid[k] = 1'b1;
                        ret_we[k]    = w_has_dst[k];
                        ret_cnt      = ret_cnt + 1'b1;
                        if (w_misp[k]) begin
                            flush     = 1'b1;
                            flush_tag = w_idx[k*TAG_W +: TAG_W];
                            stop      = 1'b1;
                        end
                    end
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
    parameter int DEPTH  = 40,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] ent_data,
    input  logic              ent_exec,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] lk_data,
    output logic              lk_ready
);
    logic hit;
    assign hit      = wb_valid && (wb_tag == lk_tag);
    assign lk_data  = hit ? wb_data : ent_data;
    assign lk_ready = hit || ent_exec;
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH  = 40,
    parameter int WIDTH  = 4,
    parameter int DATA_W = 32,
    parameter int AREG_W = 3,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int REQ_W = $clog2(WIDTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [REQ_W-1:0]        alloc_cnt,
    input  logic [WIDTH-1:0]        alloc_has_dst,
    input  logic [WIDTH*AREG_W-1:0] alloc_dst,
    output logic                    alloc_ok,
    output logic [WIDTH*TAG_W-1:0]  alloc_tag,
    input  logic                    wb_valid,
    input  logic [TAG_W-1:0]        wb_tag,
    input  logic [DATA_W-1:0]       wb_data,
    input  logic                    wb_exc,
    input  logic                    wb_misp,
    input  logic [TAG_W-1:0]        lk_tag,
    output logic [DATA_W-1:0]       lk_data,
    output logic                    lk_ready,
    output logic [WIDTH-1:0]        ret_valid,
    output logic [WIDTH-1:0]        ret_we,
    output logic [WIDTH*AREG_W-1:0] ret_addr,
    output logic [WIDTH*DATA_W-1:0] ret_data,
    output logic                    flush,
    output logic                    flush_exc,
    output logic [TAG_W-1:0]        flush_tag
);
    typedef struct packed {
        logic              valid;
        logic              exec;
        logic              exc;
        logic              misp;
        logic              has_dst;
        logic [AREG_W-1:0] dst;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [TAG_W-1:0]   head;
        logic [TAG_W-1:0]   tail;
        logic [CNT_W-1:0]   count;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0]        w_valid, w_exec, w_exc, w_misp, w_has_dst;
    logic [WIDTH*AREG_W-1:0] w_dst;
    logic [WIDTH*DATA_W-1:0] w_data;
    logic [WIDTH*TAG_W-1:0]  w_idx;
    logic [REQ_W-1:0]        ret_cnt;
    logic                    alloc_fire;
    entry_t                  lk_ent;

    // oldest WIDTH entries, slot 0 at the head
    for (genvar k = 0; k < WIDTH; k++) begin : g_win
        logic [TAG_W-1:0] idx;
        assign idx                         = TAG_W'(rob_pkg::rob_wrap(int'(st_q.head) + k, DEPTH));
        assign w_idx[k*TAG_W +: TAG_W]     = idx;
        assign w_valid[k]                  = st_q.ent[idx].valid;
        assign w_exec[k]                   = st_q.ent[idx].exec;
        assign w_exc[k]                    = st_q.ent[idx].exc;
        assign w_misp[k]                   = st_q.ent[idx].misp;
        assign w_has_dst[k]                = st_q.ent[idx].has_dst;
        assign w_dst[k*AREG_W +: AREG_W]   = st_q.ent[idx].dst;
        assign w_data[k*DATA_W +: DATA_W]  = st_q.ent[idx].data;
    end

    rob_retire #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_retire (
        .w_valid(w_valid), .w_exec(w_exec), .w_exc(w_exc), .w_misp(w_misp),
        .w_has_dst(w_has_dst), .w_dst(w_dst), .w_data(w_data), .w_idx(w_idx),
        .ret_valid(ret_valid), .ret_we(ret_we), .ret_addr(ret_addr), .ret_data(ret_data),
        .ret_cnt(ret_cnt), .flush(flush), .flush_exc(flush_exc), .flush_tag(flush_tag)
    );

    rob_alloc #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_alloc (
        .tail(st_q.tail), .count(st_q.count), .req_cnt(alloc_cnt), .flush(flush),
        .grant(alloc_ok), .fire(alloc_fire), .tags(alloc_tag)
    );

    assign lk_ent = (int'(lk_tag) < DEPTH) ? st_q.ent[lk_tag] : '0;

    rob_lookup #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_lookup (
        .lk_tag(lk_tag), .ent_data(lk_ent.data), .ent_exec(lk_ent.exec),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .lk_data(lk_data), .lk_ready(lk_ready)
    );

    always_comb begin
        st_d = st_q;
        // execution write-back into a live entry
        if (wb_valid && (int'(wb_tag) < DEPTH) && st_q.ent[wb_tag].valid) begin
            st_d.ent[wb_tag].exec = 1'b1;
            st_d.ent[wb_tag].data = wb_data;
            st_d.ent[wb_tag].exc  = wb_exc;
            st_d.ent[wb_tag].misp = wb_misp;
        end
        // free the committed entries
        for (int k = 0; k < WIDTH; k++) begin
            if (ret_valid[k]) begin
                st_d.ent[w_idx[k*TAG_W +: TAG_W]].valid = 1'b0;
            end
        end
        st_d.head  = TAG_W'(rob_pkg::rob_wrap(int'(st_q.head) + int'(ret_cnt), DEPTH));
        st_d.count = st_q.count - CNT_W'(ret_cnt);
        // new entries at the tail
        if (alloc_fire) begin
            for (int k = 0; k < WIDTH; k++) begin
                if (k < int'(alloc_cnt)) begin
                    st_d.ent[alloc_tag[k*TAG_W +: TAG_W]] = '{
                        valid: 1'b1, exec: 1'b0, exc: 1'b0, misp: 1'b0,
                        has_dst: alloc_has_dst[k],
                        dst: alloc_dst[k*AREG_W +: AREG_W],
                        data: '0};
                end
            end
            st_d.tail  = TAG_W'(rob_pkg::rob_wrap(int'(st_q.tail) + int'(alloc_cnt), DEPTH));
            st_d.count = st_d.count + CNT_W'(alloc_cnt);
        end
        // flush empties the whole buffer
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.ent[i].valid = 1'b0;
                st_d.ent[i].exec  = 1'b0;
            end
            st_d.head  = '0;
            st_d.tail  = '0;
            st_d.count = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ok,
    input logic [WIDTH-1:0] ret_valid,
    input logic [WIDTH-1:0] ret_we,
    input logic             flush,
    input logic             flush_exc
);
    // R5
    ret_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_valid + WIDTH'(1)) & ret_valid) == '0);
    // R6
    we_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_we & ~ret_valid) == '0);
    // R9
    flush_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !alloc_ok);
    // R8
    exc_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_exc |-> flush);
    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ret_valid == '0 && !flush));
endmodule

bind rob_core rob_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_ok(alloc_ok), .ret_valid(ret_valid),
    .ret_we(ret_we), .flush(flush), .flush_exc(flush_exc)
);

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb;
    localparam int DEPTH = 40, WIDTH = 4, DATA_W = 32, AREG_W = 3, TAG_W = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] alloc_cnt = '0;
    logic [WIDTH-1:0] alloc_has_dst = '0;
    logic [WIDTH*AREG_W-1:0] alloc_dst = '0;
    logic alloc_ok;
    logic [WIDTH*TAG_W-1:0] alloc_tag;
    logic wb_valid = 1'b0, wb_exc = 1'b0, wb_misp = 1'b0;
    logic [TAG_W-1:0] wb_tag = '0, lk_tag = '0;
    logic [DATA_W-1:0] wb_data = '0;
    logic [DATA_W-1:0] lk_data;
    logic lk_ready;
    logic [WIDTH-1:0] ret_valid, ret_we;
    logic [WIDTH*AREG_W-1:0] ret_addr;
    logic [WIDTH*DATA_W-1:0] ret_data;
    logic flush, flush_exc;
    logic [TAG_W-1:0] flush_tag;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rob_core u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        alloc_cnt = '0;
        wb_valid  = 1'b0;
        wb_exc    = 1'b0;
        wb_misp   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic wb(input int tag, input int data, input bit exc, input bit misp);
        wb_valid = 1'b1;
        wb_tag   = TAG_W'(tag);
        wb_data  = DATA_W'(data);
        wb_exc   = exc;
        wb_misp  = misp;
        step();
    endtask

    // request n entries, expect grant and tags first, first+1, ...
    task automatic alloc(input int n, input int first, input string req);
        alloc_cnt     = 3'(n);
        alloc_has_dst = 4'b1011;
        for (int k = 0; k < WIDTH; k++) alloc_dst[k*AREG_W +: AREG_W] = AREG_W'(k + 1);
        #1;
        chk(alloc_ok == 1'b1, req, "alloc_ok", alloc_ok, 1);
        for (int k = 0; k < n; k++)
            chk(alloc_tag[k*TAG_W +: TAG_W] == TAG_W'((first + k) % DEPTH), req, "tag",
                alloc_tag[k*TAG_W +: TAG_W], (first + k) % DEPTH);
        step();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        #1;
        chk(ret_valid == '0, "R1", "ret_valid", ret_valid, 0);
        chk(flush == 1'b0, "R1", "flush", flush, 0);
        alloc(4, 0, "R1");

        // R5 R6: every executed pattern over the four oldest entries
        for (int m = 0; m < 16; m++) begin
            int run;
            logic [3:0] expv;
            do_reset();
            alloc(4, 0, "R2");
            for (int k = 3; k >= 0; k--)
                if (m[k]) wb(k, 1000 + m * 8 + k, 1'b0, 1'b0);
            run = 0;
            while (run < 4 && m[run]) run++;
            expv = 4'((1 << run) - 1);
            #1;
            chk(ret_valid == expv, "R5", "ret_valid", ret_valid, expv);
            chk(ret_we == (expv & 4'b1011), "R6", "ret_we", ret_we, expv & 4'b1011);
            for (int k = 0; k < run; k++) begin
                chk(ret_data[k*DATA_W +: DATA_W] == DATA_W'(1000 + m * 8 + k), "R6", "ret_data",
                    ret_data[k*DATA_W +: DATA_W], 1000 + m * 8 + k);
                chk(ret_addr[k*AREG_W +: AREG_W] == AREG_W'(k + 1), "R6", "ret_addr",
                    ret_addr[k*AREG_W +: AREG_W], k + 1);
            end
            step();
            #1;
            chk(ret_valid == '0, "R5", "ret_valid after", ret_valid, 0);
        end

        // R4: lookup readiness and same-cycle bypass
        do_reset();
        alloc(4, 0, "R4");
        lk_tag = 6'd2;
        #1;
        chk(lk_ready == 1'b0, "R4", "lk_ready before", lk_ready, 0);
        wb_valid = 1'b1; wb_tag = 6'd2; wb_data = 32'd77;
        #1;
        chk(lk_ready == 1'b1, "R4", "bypass ready", lk_ready, 1);
        chk(lk_data == 32'd77, "R4", "bypass data", lk_data, 77);
        step();
        #1;
        chk(lk_ready == 1'b1 && lk_data == 32'd77, "R4", "stored data", lk_data, 77);

        // R2 R3: wrap of the tail and refusal when full
        do_reset();
        alloc(3, 0, "R2");
        for (int k = 2; k >= 0; k--) wb(k, k, 1'b0, 1'b0);
        step();
        for (int j = 0; j < 9; j++) alloc(4, 3 + 4 * j, "R2");
        alloc(4, 39, "R2");
        alloc_cnt = 3'd1;
        #1;
        chk(alloc_ok == 1'b0, "R3", "alloc_ok full", alloc_ok, 0);
        step();
        for (int k = 6; k >= 3; k--) wb(k, k, 1'b0, 1'b0);
        alloc_cnt = 3'd4;
        #1;
        chk(ret_valid == 4'b1111, "R5", "ret_valid full", ret_valid, 15);
        chk(alloc_ok == 1'b0, "R3", "alloc_ok while retiring", alloc_ok, 0);
        step();
        alloc(4, 3, "R3");

        // R8: exception at the third oldest entry
        do_reset();
        alloc(4, 0, "R8");
        wb(3, 3, 1'b0, 1'b0);
        wb(2, 2, 1'b1, 1'b0);
        wb(1, 1, 1'b0, 1'b0);
        wb(0, 0, 1'b0, 1'b0);
        alloc_cnt = 3'd1;
        #1;
        chk(ret_valid == 4'b0011, "R8", "ret_valid", ret_valid, 3);
        chk(flush && flush_exc, "R8", "flush_exc", flush_exc, 1);
        chk(flush_tag == 6'd2, "R8", "flush_tag", flush_tag, 2);
        chk(alloc_ok == 1'b0, "R9", "alloc_ok in flush", alloc_ok, 0);
        step();
        alloc(1, 0, "R8");

        // R7: mispredict at the second oldest entry
        do_reset();
        alloc(4, 0, "R7");
        wb(3, 3, 1'b0, 1'b0);
        wb(1, 11, 1'b0, 1'b1);
        wb(2, 2, 1'b0, 1'b0);
        wb(0, 10, 1'b0, 1'b0);
        #1;
        chk(ret_valid == 4'b0011, "R7", "ret_valid", ret_valid, 3);
        chk(ret_data[DATA_W +: DATA_W] == 32'd11, "R7", "branch data", ret_data[DATA_W +: DATA_W], 11);
        chk(flush && !flush_exc, "R7", "flush_exc", flush_exc, 0);
        chk(flush_tag == 6'd1, "R7", "flush_tag", flush_tag, 1);
        step();
        #1;
        chk(ret_valid == '0, "R7", "no retire after flush", ret_valid, 0);
        alloc(2, 0, "R7");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule